// File: doc/BRIEF.md
# Configuration Lock Key Sequencer

This block guards the per-pin configuration of a general-purpose I/O port. It holds a lock word made of a pin mask and a key bit. Software arms the lock by writing the lock word three times with an unchanging mask, the key bit going 1, then 0, then 1. From the third write onward the mask is frozen and published as the set of locked pins. The lock word itself stays frozen until reset.

The configuration register file that sits beside this block takes a per-bit write enable from it. For each bus write to one of the six configuration registers, the block combines the byte lanes of the access with the frozen mask. The result is expanded to the field width of the addressed register: 2 bits per pin for mode, drive speed and pull; 1 bit per pin for output type; 4 bits per pin for the two alternate-function selectors. Fields of locked pins are dropped silently. Fields of open pins in the same bus word still take the write.

Top module: `lock_key_top`

## Requirements
- R1: After reset the pin mask, the key state and `frozen_mask` are all zero, and a read of the lock word returns 0.
- R2: While unarmed, a write to the lock word (offset 0x1C) loads the mask bits in the byte lanes the access enables. Mask bit p sits at data bit p. A write that is not a word cannot arm the lock, whatever bit 16 carries.
- R3: The key bit is data bit 16. Three word writes to the lock word, with key values 1, 0, 1 and the same mask, arm the lock on the clock edge of the third write. `frozen_mask` equals the mask from the following cycle onward.
- R4: A changed mask, or a key value out of order, returns the sequencer to idle. Arming then needs a fresh three-write sequence.
- R5: A byte or half-word write to the lock word during a sequence aborts it, and that write is still applied to the mask.
- R6: Reads, and writes to other addresses, between sequence steps neither abort nor advance the sequence.
- R7: Once armed, the mask and the armed state ignore all further writes until reset.
- R8: With the read strobe high at the lock address, `lock_rdata` shows the mask in bits 15:0 and the armed state in bit 16, with all other bits 0. In every other case it returns 0.
- R9: For word writes to mode (0x00), speed (0x08) or pull (0x0C), `cfg_wr_bits` bits 2p+1:2p are 0 for each frozen pin p and 1 otherwise.
- R10: For writes to output type (0x04), bit p follows pin p, and bits 31:16 are never enabled.
- R11: For the low alternate-function selector (0x20), bits 4p+3:4p belong to pin p (pins 0 to 7). For the high selector (0x24), they belong to pin p+8.
- R12: Size code 00 is a byte, 01 is a half word, 10 is a word and 11 enables nothing. A byte access enables lane addr[1:0]. A half word enables lanes 1:0 or 3:2, chosen by addr[1]. `cfg_wr_bits` is 0 with no write strobe, and for any address that is not a configuration register.
- R13: Until the lock is armed, `frozen_mask` is 0 and no configuration field is blocked, whatever mask is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (system or peripheral) |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size code (00 byte, 01 half, 10 word) |
| bus_wdata | input | 32 | Write data |
| lock_rdata | output | 32 | Lock word readback |
| frozen_mask | output | PINS | Pins whose configuration is locked |
| cfg_wr_bits | output | 32 | Per-bit write enable for the addressed configuration register |

## Verification
The bench uses the default build: sixteen pins, 8-bit addresses and the standard register offsets. With sixteen pins the mask fills the whole low half-word, so the key bit sits directly above it in byte lane 2. A half-word write can then change the mask without ever reaching the key. With sixteen pins the high alternate-function selector also has live pins, so both selectors, pin 15 in the speed byte and the reserved upper half of the output-type register can all be checked against one armed mask, 0x8101.

// File: rtl/lock_key_pkg.sv
package lock_key_pkg;

   localparam int BUS_W   = 32;
   localparam int LANES   = BUS_W / 8;
   localparam int KEY_BIT = 16;
   localparam int MAX_PINS = 16;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'b00,
      ACC_HALF = 2'b01,
      ACC_WORD = 2'b10,
      ACC_NONE = 2'b11
   } acc_size_e;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'b00,
      SEQ_SAW_SET = 2'b01,
      SEQ_SAW_CLR = 2'b10
   } seq_state_e;

endpackage

// File: rtl/lock_lane_dec.sv
module lock_lane_dec
   import lock_key_pkg::*;
(
   input  logic [1:0]       size,
   input  logic [1:0]       byte_off,
   output logic [LANES-1:0] lanes,
   output logic             is_word
);

   always_comb begin
      lanes   = '0;
      is_word = 1'b0;
      case (acc_size_e'(size))
         ACC_BYTE: lanes[byte_off] = 1'b1;
         ACC_HALF: lanes = byte_off[1] ? 4'b1100 : 4'b0011;
         ACC_WORD: begin
            lanes   = 4'b1111;
            is_word = 1'b1;
         end
         default: lanes = '0;
      endcase
   end

endmodule

// File: rtl/lock_key_seq.sv
module lock_key_seq
   import lock_key_pkg::*;
#(
   parameter int PINS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic             is_word,
   input  logic [LANES-1:0] lanes,
   input  logic [KEY_BIT:0] wdata,
   output logic [PINS-1:0]  mask_q,
   output logic             armed_q
);

   seq_state_e      st_q, st_d;
   logic            arm_d;
   logic [PINS-1:0] bit_en, mask_d;
   logic            key, same_mask, open_wr;
   logic            unused_in;

   assign unused_in = ^{lanes, wdata};
   assign key       = wdata[KEY_BIT];
   assign same_mask = (wdata[PINS-1:0] == mask_q);
   assign open_wr   = wr_hit && !armed_q;

   for (genvar i = 0; i < PINS; i++) begin : g_bit_en
      assign bit_en[i] = lanes[i/8];
   end

   always_comb begin
      for (int i = 0; i < PINS; i++)
         mask_d[i] = (open_wr && bit_en[i]) ? wdata[i] : mask_q[i];
   end

   always_comb begin
      st_d  = st_q;
      arm_d = 1'b0;
      if (open_wr) begin
         case (st_q)
            SEQ_IDLE:    if (is_word && key) st_d = SEQ_SAW_SET;
            SEQ_SAW_SET: st_d = (is_word && !key && same_mask) ? SEQ_SAW_CLR : SEQ_IDLE;
            SEQ_SAW_CLR: begin
               st_d  = SEQ_IDLE;
               arm_d = is_word && key && same_mask;
            end
            default:     st_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         armed_q <= 1'b0;
         mask_q  <= '0;
      end else begin
         st_q    <= st_d;
         armed_q <= armed_q | arm_d;
         mask_q  <= mask_d;
      end
   end

endmodule

// File: rtl/lock_cfg_gate.sv
module lock_cfg_gate
   import lock_key_pkg::*;
#(
   parameter int                PINS      = 16,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] OFF_MODE  = 'h00,
   parameter logic [ADDR_W-1:0] OFF_OTYPE = 'h04,
   parameter logic [ADDR_W-1:0] OFF_SPEED = 'h08,
   parameter logic [ADDR_W-1:0] OFF_PULL  = 'h0C,
   parameter logic [ADDR_W-1:0] OFF_AFL   = 'h20,
   parameter logic [ADDR_W-1:0] OFF_AFH   = 'h24
) (
   input  logic              wr_en,
   input  logic [ADDR_W-3:0] addr_word,
   input  logic [LANES-1:0]  lanes,
   input  logic [PINS-1:0]   frozen,
   output logic [BUS_W-1:0]  cfg_we
);

   logic [MAX_PINS-1:0] fz;
   logic sel_two, sel_ot, sel_afl, sel_afh;

   always_comb begin
      fz = '0;
      fz[PINS-1:0] = frozen;
   end

   assign sel_two = (addr_word == OFF_MODE[ADDR_W-1:2]) ||
                    (addr_word == OFF_SPEED[ADDR_W-1:2]) ||
                    (addr_word == OFF_PULL[ADDR_W-1:2]);
   assign sel_ot  = (addr_word == OFF_OTYPE[ADDR_W-1:2]);
   assign sel_afl = (addr_word == OFF_AFL[ADDR_W-1:2]);
   assign sel_afh = (addr_word == OFF_AFH[ADDR_W-1:2]);

   for (genvar b = 0; b < BUS_W; b++) begin : g_bit
      logic ot_open;
      if (b < MAX_PINS) begin : g_ot
         assign ot_open = ~fz[b];
      end else begin : g_ot_rsvd
         assign ot_open = 1'b0;
      end
      assign cfg_we[b] = wr_en & lanes[b/8] &
                         ((sel_two & ~fz[b/2]) |
                          (sel_ot  & ot_open)  |
                          (sel_afl & ~fz[b/4]) |
                          (sel_afh & ~fz[b/4 + 8]));
   end

endmodule

// File: rtl/lock_key_top.sv
module lock_key_top
   import lock_key_pkg::*;
#(
   parameter int                PINS      = 16,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] OFF_MODE  = 'h00,
   parameter logic [ADDR_W-1:0] OFF_OTYPE = 'h04,
   parameter logic [ADDR_W-1:0] OFF_SPEED = 'h08,
   parameter logic [ADDR_W-1:0] OFF_PULL  = 'h0C,
   parameter logic [ADDR_W-1:0] OFF_LOCK  = 'h1C,
   parameter logic [ADDR_W-1:0] OFF_AFL   = 'h20,
   parameter logic [ADDR_W-1:0] OFF_AFH   = 'h24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_size,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       lock_rdata,
   output logic [PINS-1:0]   frozen_mask,
   output logic [31:0]       cfg_wr_bits
);

   if (PINS < 1 || PINS > MAX_PINS) begin : g_bad_pins
      $error("lock_key_top: PINS must lie in 1..16");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("lock_key_top: ADDR_W too small for the register offsets");
   end

   logic [LANES-1:0] lanes;
   logic             is_word, hit_lock, key_armed;
   logic [PINS-1:0]  key_mask;
   logic             unused_wd;

   assign unused_wd = ^bus_wdata[BUS_W-1:KEY_BIT+1];
   assign hit_lock  = (bus_addr[ADDR_W-1:2] == OFF_LOCK[ADDR_W-1:2]);

   lock_lane_dec u_lanes (
      .size     (bus_size),
      .byte_off (bus_addr[1:0]),
      .lanes    (lanes),
      .is_word  (is_word)
   );

   lock_key_seq #(.PINS(PINS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (bus_wr && hit_lock),
      .is_word (is_word),
      .lanes   (lanes),
      .wdata   (bus_wdata[KEY_BIT:0]),
      .mask_q  (key_mask),
      .armed_q (key_armed)
   );

   lock_cfg_gate #(
      .PINS(PINS), .ADDR_W(ADDR_W),
      .OFF_MODE(OFF_MODE), .OFF_OTYPE(OFF_OTYPE), .OFF_SPEED(OFF_SPEED),
      .OFF_PULL(OFF_PULL), .OFF_AFL(OFF_AFL), .OFF_AFH(OFF_AFH)
   ) u_gate (
      .wr_en     (bus_wr),
      .addr_word (bus_addr[ADDR_W-1:2]),
      .lanes     (lanes),
      .frozen    (frozen_mask),
      .cfg_we    (cfg_wr_bits)
   );

   always_comb begin
      frozen_mask = key_armed ? key_mask : '0;
   end

   always_comb begin
      lock_rdata = '0;
      if (bus_rd && hit_lock) begin
         lock_rdata[KEY_BIT]    = key_armed;
         lock_rdata[PINS-1:0]   = key_mask;
      end
   end

endmodule

// File: rtl/lock_key_chk.sv
module lock_key_chk #(
   parameter int                PINS      = 16,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] OFF_MODE  = 'h00,
   parameter logic [ADDR_W-1:0] OFF_OTYPE = 'h04,
   parameter logic [ADDR_W-1:0] OFF_SPEED = 'h08,
   parameter logic [ADDR_W-1:0] OFF_PULL  = 'h0C,
   parameter logic [ADDR_W-1:0] OFF_LOCK  = 'h1C
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr,
   input logic [1:0]        size,
   input logic              wd_key,
   input logic              armed,
   input logic [PINS-1:0]   frozen,
   input logic [31:0]       cfg_we
);

   logic hit_lock, hit_ot, hit_two, unused_lo;
   assign unused_lo = ^addr[1:0];
   assign hit_lock  = (addr[ADDR_W-1:2] == OFF_LOCK[ADDR_W-1:2]);
   assign hit_ot    = (addr[ADDR_W-1:2] == OFF_OTYPE[ADDR_W-1:2]);
   assign hit_two   = (addr[ADDR_W-1:2] == OFF_MODE[ADDR_W-1:2]) ||
                      (addr[ADDR_W-1:2] == OFF_SPEED[ADDR_W-1:2]) ||
                      (addr[ADDR_W-1:2] == OFF_PULL[ADDR_W-1:2]);

   // R7: armed state is sticky
   a_r7_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);

   // R7: published mask cannot move once armed
   a_r7_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> $stable(frozen));

   // R3: arming only follows a word write to the lock word with key 1
   a_r3_arm_on_key_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(wr && hit_lock && size == 2'b10 && wd_key));

   // R12: no write strobe, no enables
   a_r12_idle_bus_no_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |-> cfg_we == 32'h0);

   // R10: reserved half of output type never written
   a_r10_otype_upper_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_ot) |-> cfg_we[31:16] == 16'h0);

   // R9: two-bit fields of frozen pins stay closed
   for (genvar p = 0; p < PINS; p++) begin : g_pin
      a_r9_locked_pair_closed: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && hit_two && frozen[p]) |-> cfg_we[2*p+1 -: 2] == 2'b00);
   end

endmodule

bind lock_key_top lock_key_chk #(
   .PINS(PINS), .ADDR_W(ADDR_W), .OFF_MODE(OFF_MODE), .OFF_OTYPE(OFF_OTYPE),
   .OFF_SPEED(OFF_SPEED), .OFF_PULL(OFF_PULL), .OFF_LOCK(OFF_LOCK)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (bus_addr),
   .wr     (bus_wr),
   .size   (bus_size),
   .wd_key (bus_wdata[16]),
   .armed  (key_armed),
   .frozen (frozen_mask),
   .cfg_we (cfg_wr_bits)
);

// File: tb/sim_lock_key_top.sv
module sim_lock_key_top;

   localparam int CLK_P = 10;
   localparam int NV    = 14;

   // {req, addr, size, expected enables} with frozen mask 0x8101 armed
   localparam logic [45:0] VECS [NV] = '{
      {4'd9,  8'h00, 2'b10, 32'h3FFCFFFC},   // R9 mode word
      {4'd9,  8'h08, 2'b10, 32'h3FFCFFFC},   // R9 speed word
      {4'd9,  8'h0C, 2'b10, 32'h3FFCFFFC},   // R9 pull word
      {4'd10, 8'h04, 2'b10, 32'h00007EFE},   // R10 output type word
      {4'd11, 8'h20, 2'b10, 32'hFFFFFFF0},   // R11 low selector
      {4'd11, 8'h24, 2'b10, 32'h0FFFFFF0},   // R11 high selector
      {4'd12, 8'h0B, 2'b00, 32'h3F000000},   // R12 byte lane 3
      {4'd12, 8'h0E, 2'b01, 32'h3FFC0000},   // R12 upper half
      {4'd12, 8'h00, 2'b01, 32'h0000FFFC},   // R12 lower half
      {4'd12, 8'h05, 2'b00, 32'h00007E00},   // R12 byte lane 1
      {4'd12, 8'h24, 2'b00, 32'h000000F0},   // R12 byte lane 0
      {4'd12, 8'h1C, 2'b10, 32'h00000000},   // R12 lock word is not config
      {4'd12, 8'h14, 2'b10, 32'h00000000},   // R12 other address
      {4'd12, 8'h00, 2'b11, 32'h00000000}    // R12 size code 11
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] lock_rdata, cfg_wr_bits;
   logic [15:0] frozen_mask;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   lock_key_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .lock_rdata(lock_rdata), .frozen_mask(frozen_mask), .cfg_wr_bits(cfg_wr_bits)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] kw(input logic k, input logic [15:0] m);
      return {15'b0, k, m};
   endfunction

   task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = lock_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic gate(input logic [7:0] a, input logic [1:0] s, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_size = s; bus_wr = 1'b1;
      #1 v = cfg_wr_bits;
      bus_wr = 1'b0;
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      do_reset();

      // R1 reset state
      rd(8'h1C, v); chk("R1 readback", v, 32'h0);
      chk("R1 frozen", {16'h0, frozen_mask}, 32'h0);

      // R2 lane writes, key cannot be set by a partial write
      wr(8'h1D, 2'b00, 32'h0000AB00);
      rd(8'h1C, v); chk("R2 byte lane", v, 32'h0000AB00);
      wr(8'h1E, 2'b01, 32'h00010000);
      rd(8'h1C, v); chk("R2 partial key", v, 32'h0000AB00);

      // R13 held mask not yet effective
      chk("R13 frozen unarmed", {16'h0, frozen_mask}, 32'h0);
      gate(8'h00, 2'b10, v); chk("R13 gate open", v, 32'hFFFFFFFF);

      // R4 mask change aborts
      wr(8'h1C, 2'b10, kw(1, 16'h0F0F));
      wr(8'h1C, 2'b10, kw(0, 16'h0F0E));
      wr(8'h1C, 2'b10, kw(1, 16'h0F0E));
      rd(8'h1C, v); chk("R4 mask change", v, 32'h00000F0E);
      // R4 key out of order: 1,1 aborts, 0 does not start
      wr(8'h1C, 2'b10, kw(1, 16'h0F0E));
      wr(8'h1C, 2'b10, kw(0, 16'h0F0E));
      wr(8'h1C, 2'b10, kw(1, 16'h0F0E));
      chk("R4 key order", {16'h0, frozen_mask}, 32'h0);
      // R3 completing 1,0,1 arms
      wr(8'h1C, 2'b10, kw(0, 16'h0F0E));
      wr(8'h1C, 2'b10, kw(1, 16'h0F0E));
      chk("R3 armed after fresh sequence", {16'h0, frozen_mask}, 32'h00000F0E);

      // R5 partial write aborts but is applied
      do_reset();
      wr(8'h1C, 2'b10, kw(1, 16'h00F0));
      wr(8'h1C, 2'b10, kw(0, 16'h00F0));
      wr(8'h1C, 2'b01, 32'h00001234);
      wr(8'h1C, 2'b10, kw(1, 16'h1234));
      chk("R5 aborted", {16'h0, frozen_mask}, 32'h0);
      rd(8'h1C, v); chk("R5 mask applied", v, 32'h00001234);

      // R6 interleaved accesses do not disturb
      do_reset();
      wr(8'h1C, 2'b10, kw(1, 16'h8101));
      wr(8'h14, 2'b10, 32'h0000FFFF);
      rd(8'h1C, v); chk("R8 unarmed readback", v, 32'h00008101);
      wr(8'h1C, 2'b10, kw(0, 16'h8101));
      wr(8'h00, 2'b10, 32'hFFFFFFFF);
      chk("R6 not yet armed", {16'h0, frozen_mask}, 32'h0);
      wr(8'h1C, 2'b10, kw(1, 16'h8101));
      chk("R6 armed through interleave", {16'h0, frozen_mask}, 32'h00008101);
      rd(8'h1C, v); chk("R8 armed readback", v, 32'h00018101);

      // R7 frozen lock word
      wr(8'h1C, 2'b10, kw(0, 16'hFFFF));
      wr(8'h1C, 2'b00, 32'h0);
      wr(8'h1C, 2'b10, kw(1, 16'h0000));
      wr(8'h1C, 2'b10, kw(0, 16'h0000));
      wr(8'h1C, 2'b10, kw(1, 16'h0000));
      rd(8'h1C, v); chk("R7 lock word frozen", v, 32'h00018101);
      chk("R7 frozen mask", {16'h0, frozen_mask}, 32'h00008101);

      // R9..R12 table walk
      for (int i = 0; i < NV; i++) begin
         gate(VECS[i][41:34], VECS[i][33:32], v);
         chk($sformatf("R%0d vec %0d", VECS[i][45:42], i), v, VECS[i][31:0]);
      end

      // R12 no strobe
      @(negedge clk);
      bus_addr = 8'h00; bus_size = 2'b10;
      #1 chk("R12 no strobe", cfg_wr_bits, 32'h0);

      // R8 readback gated by strobe and address
      @(negedge clk);
      bus_addr = 8'h1C; bus_rd = 1'b0;
      #1 chk("R8 no strobe", lock_rdata, 32'h0);
      rd(8'h00, v); chk("R8 other address", v, 32'h0);

      // R1 reset clears an armed lock
      do_reset();
      chk("R1 reset after arm", {16'h0, frozen_mask}, 32'h0);
      rd(8'h1C, v); chk("R1 readback after arm", v, 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule